// File: doc/BRIEF.md
# Tribit Symbol Scrambler

This block whitens a stream of 3-bit channel symbols (values 0 to 7) before they reach an 8-PSK modulator in a serial-tone modem. A 12-bit shift register in one-to-many (Galois) form, built on the polynomial x^12+x^6+x^4+x+1, produces one 3-bit key per symbol. The key is added modulo 8 to the incoming symbol. It is not XORed with it.

For each accepted symbol the register moves forward eight single steps, all in one clock. The key is the low three bits of the advanced state. After every 160 accepted symbols the register is reloaded with the fixed seed 0xBAD, so the key stream repeats with a period of 160 symbols. A probe input forces the data symbol to zero, and the output then shows the key alone. A synchronous restart input reloads the seed at any time.

Symbols arrive on a valid/ready handshake. The scrambled result sits in a single output register that has its own valid signal and a downstream ready.

Top module: `tribit_scrambler`

## Requirements
- R1: After reset, sym_valid_o is 0, sym_ready_o is 1 and the register holds the seed 0xBAD with the symbol count at zero.
- R2: One register step shifts the state left by one bit. The old bit 11 enters bit 0, and it is also XORed into the new values of bits 6, 4 and 1.
- R3: Each accepted symbol advances the register by STEPS_PER_SYM steps (default 8). The key for that symbol is bits 2..0 of the advanced state.
- R4: A symbol is accepted in a cycle where sym_valid_i and sym_ready_o are both 1. In the next cycle sym_valid_o is 1 and sym_o equals (sym_i + key) mod 8.
- R5: If probe_i is 1 when a symbol is accepted, sym_i is replaced by 0, so sym_o equals the key.
- R6: After SYMS_PER_SEED accepted symbols (default 160), the register reloads the seed and the count returns to zero. The key for accepted symbol k therefore equals the key for symbol k mod 160.
- R7: While restart_i is 1, sym_ready_o is 0 and no symbol is accepted. On that edge the seed is reloaded, the count is cleared and sym_valid_o drops to 0.
- R8: When restart_i is 0, sym_ready_o = !sym_valid_o || dst_ready_i. While sym_valid_o is 1 and dst_ready_i is 0, sym_o and sym_valid_o hold their values. If the held output is consumed and no new symbol is accepted, sym_valid_o falls to 0.
- R9: With STEPS_PER_SYM = 1 and a reseed period above 8190, the key stream follows single register steps, and the register state returns to the seed after exactly 4095 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous reload of the seed and the count |
| probe_i | input | 1 | Forces the data symbol to zero |
| sym_valid_i | input | 1 | Input symbol valid |
| sym_i | input | 3 | Input tribit |
| sym_ready_o | output | 1 | Block can accept a symbol |
| sym_valid_o | output | 1 | Scrambled symbol valid |
| sym_o | output | 3 | Scrambled tribit |
| dst_ready_i | input | 1 | Downstream accepts sym_o |

## Verification
The hardest condition to reach from the ports is the reseed boundary, and in particular a reseed that happens while the output is stalled or a restart is pending. Only the count of accepted symbols moves the register, so the stimulus streams whole multiples of 160 symbols under probe mode. It then compares every key with the key at the same index modulo 160. Backpressure gaps and mid-period restarts are mixed into that stream. A second instance runs one step per symbol, which makes the full 4095-state cycle visible on sym_o.

// File: rtl/tribit_scr_pkg.sv
package tribit_scr_pkg;
  localparam int unsigned LFSR_W = 12;
  localparam int unsigned SYM_W  = 3;
  // bits that also take the feedback bit (besides bit 0)
  localparam logic [LFSR_W-1:0] TAP_MASK = 12'h052;
  localparam logic [LFSR_W-1:0] SEED     = 12'hBAD;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [SYM_W-1:0]  sym_t;

  function automatic lfsr_t lfsr_step(input lfsr_t s);
    logic fb;
    fb = s[LFSR_W-1];
    return {s[LFSR_W-2:0], fb} ^ ({LFSR_W{fb}} & TAP_MASK);
  endfunction
endpackage

// File: rtl/tribit_lfsr_adv.sv
module tribit_lfsr_adv
  import tribit_scr_pkg::*;
#(
  parameter int unsigned STEPS = 8
) (
  input  lfsr_t state_i,
  output lfsr_t state_o
);
  lfsr_t chain [STEPS+1];

  assign chain[0] = state_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = lfsr_step(chain[g]);
  end

  assign state_o = chain[STEPS];
endmodule

// File: rtl/tribit_sym_ctr.sv
module tribit_sym_ctr #(
  parameter int unsigned PERIOD = 160,
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(PERIOD - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tribit_mod8_add.sv
module tribit_mod8_add
  import tribit_scr_pkg::*;
(
  input  sym_t data_i,
  input  sym_t key_i,
  input  logic zero_i,
  output sym_t sum_o
);
  sym_t data_eff;

  assign data_eff = zero_i ? '0 : data_i;
  // width-limited add wraps modulo 8
  assign sum_o    = data_eff + key_i;
endmodule

// File: rtl/tribit_scrambler.sv
module tribit_scrambler
  import tribit_scr_pkg::*;
#(
  parameter int unsigned STEPS_PER_SYM = 8,
  parameter int unsigned SYMS_PER_SEED = 160,
  localparam int unsigned CNT_W = (SYMS_PER_SEED > 2) ? $clog2(SYMS_PER_SEED) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       probe_i,
  input  logic       sym_valid_i,
  input  logic [2:0] sym_i,
  output logic       sym_ready_o,
  output logic       sym_valid_o,
  output logic [2:0] sym_o,
  input  logic       dst_ready_i
);
  lfsr_t            state_q;
  lfsr_t            state_adv;
  sym_t             sum;
  logic             xfer;
  logic             last;
  logic [CNT_W-1:0] cnt_q;
  logic             out_vld_q;
  sym_t             out_sym_q;

  assign sym_ready_o = !restart_i && (!out_vld_q || dst_ready_i);
  assign xfer        = sym_valid_i && sym_ready_o;

  tribit_lfsr_adv #(.STEPS(STEPS_PER_SYM)) u_adv (
    .state_i (state_q),
    .state_o (state_adv)
  );

  tribit_sym_ctr #(.PERIOD(SYMS_PER_SEED)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .adv_i  (xfer),
    .last_o (last),
    .cnt_o  (cnt_q)
  );

  tribit_mod8_add u_add (
    .data_i (sym_i),
    .key_i  (state_adv[SYM_W-1:0]),
    .zero_i (probe_i),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else if (restart_i) begin
      state_q <= SEED;
    end else if (xfer) begin
      state_q <= last ? SEED : state_adv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_sym_q <= '0;
    end else if (restart_i) begin
      out_vld_q <= 1'b0;
    end else if (xfer) begin
      out_vld_q <= 1'b1;
      out_sym_q <= sum;
    end else if (dst_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign sym_valid_o = out_vld_q;
  assign sym_o       = out_sym_q;
endmodule

// File: rtl/tribit_scr_chk.sv
module tribit_scr_chk
  import tribit_scr_pkg::*;
#(
  parameter int unsigned SYMS_PER_SEED = 160,
  localparam int unsigned CNT_W = (SYMS_PER_SEED > 2) ? $clog2(SYMS_PER_SEED) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             sym_valid_i,
  input logic             sym_ready_o,
  input logic             sym_valid_o,
  input logic [2:0]       sym_o,
  input logic             dst_ready_i,
  input lfsr_t            state_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_RESTART_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !sym_ready_o); // R7
  AST_RESTART_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == SEED) && (cnt_q == '0) && !sym_valid_o); // R7
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !dst_ready_i && !restart_i) |=> sym_valid_o && $stable(sym_o)); // R8
  AST_FREE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sym_valid_o && !restart_i) |-> sym_ready_o); // R8
  AST_OUT_ON_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o) |=> sym_valid_o); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(SYMS_PER_SEED)); // R6
  AST_RESEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o && cnt_q == CNT_W'(SYMS_PER_SEED - 1))
      |=> (state_q == SEED) && (cnt_q == '0)); // R6
  AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R2
endmodule

bind tribit_scrambler tribit_scr_chk #(.SYMS_PER_SEED(SYMS_PER_SEED)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .sym_valid_i (sym_valid_i),
  .sym_ready_o (sym_ready_o),
  .sym_valid_o (sym_valid_o),
  .sym_o       (sym_o),
  .dst_ready_i (dst_ready_i),
  .state_q     (state_q),
  .cnt_q       (cnt_q)
);

// File: tb/tb_tribit_scrambler.sv
module tb_tribit_scrambler;
  localparam logic [11:0] SEED_M = 12'hBAD;
  localparam int PER = 160;
  localparam int S1_LEN = 8190;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       restart = 0, probe = 0, vin = 0, dst = 1;
  logic [2:0] sin = 0;
  logic       rdy_o, vld_o;
  logic [2:0] so;

  logic       s1_vin = 0;
  logic       s1_rdy, s1_vld;
  logic [2:0] s1_so;

  int total = 0;
  int bad = 0;

  tribit_scrambler dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .probe_i(probe),
    .sym_valid_i(vin), .sym_i(sin), .sym_ready_o(rdy_o),
    .sym_valid_o(vld_o), .sym_o(so), .dst_ready_i(dst)
  );

  tribit_scrambler #(.STEPS_PER_SYM(1), .SYMS_PER_SEED(9000)) dut_step1 (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(1'b0), .probe_i(1'b1),
    .sym_valid_i(s1_vin), .sym_i(3'd5), .sym_ready_o(s1_rdy),
    .sym_valid_o(s1_vld), .sym_o(s1_so), .dst_ready_i(1'b1)
  );

  function automatic logic [11:0] m_step(input logic [11:0] s);
    logic [11:0] n;
    n = {s[10:0], s[11]};
    if (s[11]) begin
      n[6] = n[6] ^ 1'b1;
      n[4] = n[4] ^ 1'b1;
      n[1] = n[1] ^ 1'b1;
    end
    return n;
  endfunction

  logic [11:0] m_st = SEED_M;
  int          m_cnt = 0;
  logic        m_vld = 0;
  logic [2:0]  m_sym = 0;
  logic [2:0]  pout [480];
  logic [2:0]  s1_out [S1_LEN];

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] s, input logic p,
                     input logic r, input logic d, input string tag);
    logic        exp_rdy;
    logic [11:0] n;
    vin = v; sin = s; probe = p; restart = r; dst = d;
    #1;
    exp_rdy = !r && (!m_vld || d);
    chk(int'(rdy_o), int'(exp_rdy), r ? "R7" : "R8");
    if (r) begin
      m_st = SEED_M; m_cnt = 0; m_vld = 0;
    end else if (v && exp_rdy) begin
      n = m_st;
      for (int i = 0; i < 8; i++) n = m_step(n);
      m_sym = 3'((p ? 3'd0 : s) + n[2:0]);
      m_vld = 1;
      if (m_cnt == PER - 1) begin
        m_st = SEED_M; m_cnt = 0;
      end else begin
        m_st = n; m_cnt++;
      end
    end else if (d) begin
      m_vld = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(vld_o), int'(m_vld), tag);
    if (m_vld) chk(int'(so), int'(m_sym), tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [11:0] st;
    int          per;
    repeat (3) @(negedge clk);
    chk(int'(vld_o), 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(vld_o), 0, "R1");
    chk(int'(rdy_o), 1, "R1");

    // first key from seed: R1 R3
    cyc(1, 3'd0, 0, 0, 1, "R3");
    // data stream through a whole period, every input value
    for (int k = 1; k < PER; k++) cyc(1, 3'(k * 3), 0, 0, 1, "R4");

    // keys alone over three periods
    for (int k = 0; k < 480; k++) begin
      cyc(1, 3'(k), 1, 0, 1, "R5");
      pout[k] = so;
    end
    for (int k = PER; k < 480; k++) chk(int'(pout[k]), int'(pout[k % PER]), "R6");

    // backpressure and input gaps
    for (int k = 0; k < 400; k++)
      cyc((k % 4) != 3, 3'(k ^ 3), (k % 5) == 0, 0, (k % 3) != 1, "R8");

    // restart mid-period, also while output stalled
    for (int k = 0; k < 50; k++) cyc(1, 3'(k), 0, 0, 1, "R4");
    cyc(1, 3'd1, 0, 0, 0, "R8");
    cyc(1, 3'd5, 0, 1, 0, "R7");
    for (int k = 0; k < 20; k++) cyc(1, 3'(7 - k), 0, 0, 1, "R7");
    cyc(1, 3'd2, 1, 1, 1, "R7");
    for (int v = 0; v < 8; v++) begin
      cyc(1, 3'(v), 0, 1, 1, "R7");
      cyc(1, 3'(v), 0, 0, 1, "R4");
    end
    // restart right at the reseed point
    for (int k = 0; k < PER - 1; k++) cyc(1, 3'(k), 1, 0, 1, "R6");
    cyc(1, 3'd0, 0, 1, 1, "R7");
    for (int k = 0; k < 5; k++) cyc(1, 3'(k), 1, 0, 1, "R6");
    vin = 0;

    // single-step instance: R2 R9
    st = SEED_M;
    s1_vin = 1;
    for (int k = 0; k < S1_LEN; k++) begin
      st = m_step(st);
      @(posedge clk);
      @(negedge clk);
      s1_out[k] = s1_so;
      chk(int'(s1_vld), 1, "R2");
      chk(int'(s1_so), int'(st[2:0]), "R2");
    end
    s1_vin = 0;
    for (int k = 4095; k < S1_LEN; k++) chk(int'(s1_out[k]), int'(s1_out[k - 4095]), "R9");
    st = m_step(SEED_M);
    per = 1;
    while (st != SEED_M && per < 5000) begin
      st = m_step(st);
      per++;
    end
    chk(per, 4095, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule